// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Engine

This block sits between a serial memory's protocol front end and its storage array. When a transfer begins, the front end loads a word address into the pointer. Each incoming data byte then lands in a small page buffer at the pointer's in-page offset. Only the low offset bits of the pointer advance, so a long burst wraps inside the same page and replaces bytes it stored earlier. The storage array sees nothing while bytes arrive.

When the front end reports the end of the transfer with a commit strobe, the block enters a self-timed write cycle. It holds a busy flag for a fixed number of system clocks. During the first cycles of that window it scans the page buffer and drives a write port into the array, once for each buffer entry written in this transfer; all other locations of the page keep their contents. A supply-low input stands for a low-voltage detector: a commit requested while it is high is refused, and while it is high during a cycle no array write is issued. The front end can poll busy to decide whether to acknowledge new traffic.

Top module: `page_write_engine`

## Requirements
- R1: While reset is asserted and right after it, busy and memWe are 0 and curPtr is 0.
- R2: When idle, an addrLoad pulse sets curPtr to addrIn on the next cycle and discards all buffered bytes from earlier transfers.
- R3: When idle, each byteStb stores byteData at buffer offset curPtr[3:0] and adds one to curPtr[3:0], wrapping from 15 to 0, while curPtr[6:4] does not change.
- R4: When more than 16 bytes arrive before a commit, a later byte replaces the earlier byte at the same offset, and only the last value at each offset is written to the array.
- R5: memWe is 0 whenever busy is 0, so the array is never written before a commit.
- R6: An idle commitStb, with supplyLow at 0 and at least one buffered byte, raises busy on the next cycle for exactly CYCLE_CLKS cycles. In busy cycle k, for k from 0 to 15, memAddr is {curPtr[6:4], k} and memWdata is the byte last stored at offset k.
- R7: In the scan cycle of an offset with no byte stored in the current transfer, memWe stays 0, so that array location keeps its old value.
- R8: While busy, byteStb, addrLoad and commitStb are ignored: curPtr does not change and no new cycle starts.
- R9: A commitStb with supplyLow at 1 starts no cycle and issues no write. The bytes of that transfer are discarded, so a later commit with no new bytes also starts no cycle.
- R10: During a write cycle, memWe is 0 in any cycle in which supplyLow is 1.
- R11: A commitStb with no buffered byte does not raise busy.
- R12: Buffered-byte marks are cleared by an address load and by the end of each write cycle. A commit issued after either of these, with no new bytes, does not raise busy.
- R13: When several strobes arrive in the same idle cycle, commitStb wins over addrLoad and addrLoad wins over byteStb. A strobe that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Load addrIn into the pointer and start a new transfer |
| addrIn | input | ADDR_W | Word address to load |
| byteStb | input | 1 | One data byte received |
| byteData | input | DATA_W | Received data byte |
| commitStb | input | 1 | Transfer ended; commit the buffer |
| supplyLow | input | 1 | Supply below the safe write level |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| curPtr | output | ADDR_W | Current address pointer |

## Verification
Some rules are checked by assertions on every cycle: array writes occur only inside a busy window and never while supply is low, each busy window lasts exactly the cycle length, the pointer stays frozen while busy, and the page bits stay fixed across a byte strobe. Other rules can only be shown by the bench's scenarios, because they depend on the history of a whole transfer. These are the rule that the last byte at each offset is the one written, which offsets are skipped, how marks are cleared by address loads and by completed cycles, the effect of a refused commit, and the priority between strobes that arrive together.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  // One-hot-or-none actions chosen by the control each cycle
  typedef struct packed {
    logic loadAddr;    // take a new word address, drop marks
    logic writeByte;   // store a byte at the pointer offset
    logic startCycle;  // begin the self-timed commit
    logic clearMarks;  // forget which entries were written
  } pweStrobes_t;
endpackage

// File: rtl/pwe_ctrl.sv
module pwe_ctrl #(
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 40   // must be at least 1 << PAGE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                addrLoad,
  input  logic                byteStb,
  input  logic                commitStb,
  input  logic                supplyLow,
  input  logic                anyMarked,
  output pwe_pkg::pweStrobes_t stb,
  output logic                busy,
  output logic                scanActive,
  output logic [PAGE_W-1:0]   scanIdx
);
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int CNT_W   = $clog2(CYCLE_CLKS + 1);

  logic [CNT_W-1:0] cnt;
  logic             lastCnt;

  assign lastCnt = (cnt == CNT_W'(CYCLE_CLKS - 1));

  // Commit beats address load, which beats a byte strobe
  always_comb begin
    stb = '0;
    if (!busy) begin
      if (commitStb) begin
        if (!supplyLow && anyMarked) stb.startCycle = 1'b1;
        else                         stb.clearMarks = 1'b1;
      end else if (addrLoad) begin
        stb.loadAddr = 1'b1;
      end else if (byteStb) begin
        stb.writeByte = 1'b1;
      end
    end else if (lastCnt) begin
      stb.clearMarks = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (stb.startCycle) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (lastCnt) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign scanActive = busy && (cnt < CNT_W'(PAGE_SZ));
  assign scanIdx    = cnt[PAGE_W-1:0];
endmodule

// File: rtl/pwe_datapath.sv
module pwe_datapath #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwe_pkg::pweStrobes_t stb,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    byteData,
  input  logic                 supplyLow,
  input  logic                 scanActive,
  input  logic [PAGE_W-1:0]    scanIdx,
  output logic                 anyMarked,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [ADDR_W-1:0]    curPtr
);
  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [ADDR_W-1:0]  ptr;
  logic [PAGE_SZ-1:0] mark;
  logic [DATA_W-1:0]  pageBuf [PAGE_SZ];

  // Pointer: only the in-page offset moves on a byte
  always_ff @(posedge clk) begin
    if (!rstN)               ptr <= '0;
    else if (stb.loadAddr)   ptr <= addrIn;
    else if (stb.writeByte)  ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  end

  // Buffer entries and their written marks
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_SZ; i++) begin
      if (!rstN) begin
        pageBuf[i] <= '0;
        mark[i]    <= 1'b0;
      end else if (stb.loadAddr || stb.clearMarks) begin
        mark[i] <= 1'b0;
      end else if (stb.writeByte && (ptr[PAGE_W-1:0] == PAGE_W'(i))) begin
        pageBuf[i] <= byteData;
        mark[i]    <= 1'b1;
      end
    end
  end

  assign anyMarked = |mark;
  assign memWe     = scanActive && mark[scanIdx] && !supplyLow;
  assign memAddr   = {ptr[ADDR_W-1:PAGE_W], scanIdx};
  assign memWdata  = pageBuf[scanIdx];
  assign curPtr    = ptr;
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commitStb,
  input  logic              supplyLow,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy,
  output logic [ADDR_W-1:0] curPtr
);
  pwe_pkg::pweStrobes_t stb;
  logic                 anyMarked;
  logic                 scanActive;
  logic [PAGE_W-1:0]    scanIdx;

  pwe_ctrl #(.PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteStb(byteStb),
    .commitStb(commitStb), .supplyLow(supplyLow), .anyMarked(anyMarked),
    .stb(stb), .busy(busy), .scanActive(scanActive), .scanIdx(scanIdx)
  );

  pwe_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addrIn(addrIn), .byteData(byteData),
    .supplyLow(supplyLow), .scanActive(scanActive), .scanIdx(scanIdx),
    .anyMarked(anyMarked), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .curPtr(curPtr)
  );
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] addrIn,
  input logic              byteStb,
  input logic              commitStb,
  input logic              supplyLow,
  input logic              memWe,
  input logic              busy,
  input logic [ADDR_W-1:0] curPtr
);
  // Length of the current busy window, counted here rather than with a deep $past
  logic [31:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= '0;
  end

  p_cycle_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == 32'(CYCLE_CLKS));

  p_cycle_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyLen < 32'(CYCLE_CLKS));

  p_we_in_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  p_we_supply_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !supplyLow);

  p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curPtr));

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && addrLoad && !commitStb) |=> curPtr == $past(addrIn));

  p_page_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteStb && !addrLoad && !commitStb) |=>
      (curPtr[ADDR_W-1:PAGE_W] == $past(curPtr[ADDR_W-1:PAGE_W])) &&
      (curPtr[PAGE_W-1:0] == $past(curPtr[PAGE_W-1:0]) + PAGE_W'(1)));

  p_refused_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commitStb && supplyLow) |=> !busy);
endmodule

bind page_write_engine pwe_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_pwe_checker (
  .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
  .byteStb(byteStb), .commitStb(commitStb), .supplyLow(supplyLow),
  .memWe(memWe), .busy(busy), .curPtr(curPtr)
);

// File: tb/test_page_write_engine.sv
`timescale 1ns/1ps
module test_page_write_engine;
  localparam int ADDR_W = 7;
  localparam int PAGE_W = 4;
  localparam int DATA_W = 8;
  localparam int CYC    = 40;
  localparam int PSZ    = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rstN;
  logic addrLoad, byteStb, commitStb, supplyLow;
  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] byteData;
  logic memWe, busy;
  logic [ADDR_W-1:0] memAddr, curPtr;
  logic [DATA_W-1:0] memWdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the transfer state
  logic [ADDR_W-1:0] mPtr;
  logic [DATA_W-1:0] mBuf [PSZ];
  logic [PSZ-1:0]    mMark;

  always #5 clk = ~clk;

  page_write_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYC))
  i_page_write_engine (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteStb(byteStb), .byteData(byteData), .commitStb(commitStb),
    .supplyLow(supplyLow), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .busy(busy), .curPtr(curPtr)
  );

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:PAGE_W], p[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    addrLoad = 0; byteStb = 0; commitStb = 0; supplyLow = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic loadA(input logic [ADDR_W-1:0] a);
    addrLoad = 1; addrIn = a; tick();
    mPtr = a; mMark = '0;
  endtask

  task automatic putByte(input logic [DATA_W-1:0] d);
    byteStb = 1; byteData = d; tick();
    mBuf[mPtr[PAGE_W-1:0]] = d; mMark[mPtr[PAGE_W-1:0]] = 1'b1; mPtr = nextPtr(mPtr);
  endtask

  task automatic checkPtr(input string tag);
    @(negedge clk);
    chk(curPtr == mPtr, tag, int'(curPtr), int'(mPtr));
    @(posedge clk); #1;
  endtask

  // Commit and walk the whole busy window; noise drives ignored strobes,
  // others adds losing strobes to the commit cycle, lowAt pulses supplyLow
  task automatic commitRun(input bit noise, input bit others, input int lowAt);
    commitStb = 1;
    if (others) begin
      addrLoad = 1; addrIn = ADDR_W'($urandom); byteStb = 1; byteData = DATA_W'($urandom);
    end
    tick();
    if (mMark == '0) begin
      @(negedge clk);
      chk(busy == 1'b0, "R11 R12 no cycle without buffered bytes", int'(busy), 0);
      @(posedge clk); #1;
      return;
    end
    for (int k = 0; k < CYC; k++) begin
      if (noise) begin
        addrLoad = 1'($urandom); addrIn = ADDR_W'($urandom);
        byteStb = 1'($urandom); byteData = DATA_W'($urandom); commitStb = 1'($urandom);
      end
      supplyLow = (k == lowAt);
      @(negedge clk);
      chk(busy == 1'b1, "R6 busy window", int'(busy), 1);
      if (k < PSZ) begin
        if (mMark[k] && k != lowAt) begin
          chk(memWe == 1'b1, "R6 write issued", int'(memWe), 1);
          chk(memAddr == {mPtr[ADDR_W-1:PAGE_W], PAGE_W'(k)}, "R6 write address",
              int'(memAddr), int'({mPtr[ADDR_W-1:PAGE_W], PAGE_W'(k)}));
          chk(memWdata == mBuf[k], "R4 R6 write data", int'(memWdata), int'(mBuf[k]));
        end else if (k == lowAt) begin
          chk(memWe == 1'b0, "R10 write held off by supplyLow", int'(memWe), 0);
        end else begin
          chk(memWe == 1'b0, "R7 unwritten entry skipped", int'(memWe), 0);
        end
      end else begin
        chk(memWe == 1'b0, "R6 no write after scan", int'(memWe), 0);
      end
      tick();
    end
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy ends after CYCLE_CLKS", int'(busy), 0);
    chk(curPtr == mPtr, "R8 pointer kept while busy", int'(curPtr), int'(mPtr));
    mMark = '0;
    @(posedge clk); #1;
  endtask

  task automatic refusedCommit();
    commitStb = 1; supplyLow = 1; tick();
    @(negedge clk);
    chk(busy == 1'b0, "R9 refused commit", int'(busy), 0);
    chk(memWe == 1'b0, "R9 no write on refusal", int'(memWe), 0);
    @(posedge clk); #1;
    mMark = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; clearIn(); addrIn = '0; byteData = '0;
    mPtr = '0; mMark = '0;
    for (int i = 0; i < PSZ; i++) mBuf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && memWe == 1'b0, "R1 outputs in reset", int'({busy, memWe}), 0);
    chk(curPtr == '0, "R1 pointer in reset", int'(curPtr), 0);
    @(posedge clk); #1; rstN = 1;
    checkPtr("R1 pointer after reset");

    // Basic load, short burst, commit
    loadA(7'h23); checkPtr("R2 address load");
    putByte(8'hA1); putByte(8'hB2); putByte(8'hC3);
    checkPtr("R3 pointer advance");
    commitRun(0, 0, -1);

    // Offset wrap inside the page, with ignored strobes during the cycle
    loadA(7'h7E);
    putByte(8'h11); putByte(8'h22); putByte(8'h33); putByte(8'h44);
    checkPtr("R3 wrap keeps page bits");
    commitRun(1, 0, -1);

    // Overrun beyond 16 bytes, with a supply dip at scan slot 5
    loadA(7'h40);
    for (int i = 0; i < 20; i++) putByte(DATA_W'($urandom));
    checkPtr("R4 pointer after overrun");
    commitRun(0, 0, 5);

    // Marks gone after a completed cycle
    commitRun(0, 0, -1);

    // Marks gone after an address load
    loadA(7'h10); putByte(8'h5A); putByte(8'h6B);
    loadA(7'h18); checkPtr("R12 reload");
    commitRun(0, 0, -1);

    // Commit refused while supply low; buffered bytes discarded
    loadA(7'h31); putByte(8'h77); putByte(8'h88);
    refusedCommit();
    commitRun(0, 0, -1);

    // Priority: addrLoad beats byteStb
    loadA(7'h05); putByte(8'h99);
    addrLoad = 1; addrIn = 7'h62; byteStb = 1; byteData = 8'hEE; tick();
    mPtr = 7'h62; mMark = '0;
    checkPtr("R13 load beats byte");
    commitRun(0, 0, -1);
    // Priority: commit beats load and byte
    putByte(8'h3C); putByte(8'h4D);
    commitRun(0, 1, -1);
    checkPtr("R13 commit beats load and byte");

    // Constrained random transfers
    for (int t = 0; t < 30; t++) begin
      int n;
      loadA(ADDR_W'($urandom));
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) putByte(DATA_W'($urandom));
      checkPtr("R3 random burst pointer");
      if ($urandom % 6 == 0) refusedCommit();
      commitRun(1'($urandom), 0, ($urandom % 3 == 0) ? int'($urandom % PSZ) : -1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule